// File: doc/BRIEF.md
# Vector Arithmetic Word Shift Unit

This execute unit handles one vector instruction per clock on a machine with 128-bit vector registers. It looks at a 32-bit instruction word and its valid flag. It accepts two encodings of the same operation. The compact encoding carries 5-bit register indices. The wide encoding carries 7-bit indices whose upper bits are spread over the low end of the word. From the decoded source indices it drives two register-file read addresses in the same cycle, and it takes the two 128-bit operands back combinationally.

Each operand is split into four 32-bit lanes. In every lane, the word from the first source is shifted right with sign fill. The shift count comes from the bottom five bits of the matching lane of the second source. One clock after a valid instruction, the unit presents the destination index, the 128-bit result and a write-enable. A valid word that matches neither encoding raises an unrecognised flag instead and causes no write. The unit has no condition or status side effects.

Top module: `vsa_unit`

## Requirements
- R1: Bits are numbered with doc bit k equal to `in_instr[31-k]`. A word with bits 0–5 equal to 4 and bits 21–31 equal to 900 (`32'h10000384` with zero register fields) is the compact form. Its destination, source A and source B indices are bits 6–10, 11–15 and 16–20, each zero-extended to 7 bits. One clock after it is presented with `in_valid`, `wb_en` is 1 and `wb_addr` holds the destination.
- R2: A word with bits 0–5 equal to 6 and bits 23–25 equal to 3'b101 (`32'h18000150` with zero register fields) is the wide form. Its source A index is {bit21, bit26, bits 11–15}, its destination is {bits 28–29, bits 6–10} and its source B is {bits 30–31, bits 16–20}, with the first-named bit most significant.
- R3: Each 32-bit result lane is the source A lane shifted right by the count, with the sign bit copied into every vacated position. A count of 0 returns the lane unchanged. A count of 31 gives all zeros or all ones.
- R4: Each lane's count is bits [4:0] of the same lane of source B. Bits [31:5] of that lane have no effect on the result.
- R5: Lane 0 occupies bits [127:96] and lane 3 occupies bits [31:0]. Each lane uses only its own count.
- R6: A valid word that matches neither form sets `bad_op` to 1 one clock later with `wb_en` at 0. This includes a wide-form word whose bits 23–25 differ from 3'b101. `wb_en` and `bad_op` are never both 1.
- R7: In the wide form, reserved bits 22 and 27 are not compared. Either value still decodes and writes back.
- R8: A synchronous active-high `rst` clears `wb_en` and `bad_op`. While `in_valid` is 0, both are 0 on the next clock, whatever the instruction bits are.
- R9: `rd_addr_a` and `rd_addr_b` show the decoded source indices of the current `in_instr` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present |
| in_instr | input | 32 | Instruction word |
| rd_addr_a | output | 7 | Read index for source A |
| rd_addr_b | output | 7 | Read index for source B |
| rd_data_a | input | 128 | Source A operand for the current instruction |
| rd_data_b | input | 128 | Source B operand for the current instruction |
| wb_en | output | 1 | Write-back enable, one clock after a recognised instruction |
| wb_addr | output | 7 | Destination index |
| wb_data | output | 128 | Shifted result |
| bad_op | output | 1 | Unrecognised valid instruction, one clock later |

## Verification
The operand vectors mix positive and negative lanes with different counts per lane, including 0 and 31. This separates sign fill from zero fill and exposes any swap of lanes or of counts between lanes. Count lanes with their upper 27 bits set test that only five bits reach the shifter. Wide-form words with large index values, with the reserved bits flipped and with one opcode bit off show whether the scattered index bits are reassembled in the right order and whether the match is neither too loose nor too strict. Random words and operands then cover the decode and the datapath together.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    parameter int unsigned LANE_W    = 32;
    parameter int unsigned LANES     = 4;
    parameter int unsigned VEC_W     = LANE_W * LANES;
    parameter int unsigned IDX_W     = 7;
    parameter int unsigned SIDX_W    = 5;
    parameter int unsigned INSTR_W   = 32;
    localparam int unsigned CNT_W    = $clog2(LANE_W);

    localparam logic [5:0]  OP_SHORT = 6'd4;
    localparam logic [5:0]  OP_WIDE  = 6'd6;
    localparam logic [10:0] XO_SHORT = 11'd900;
    localparam logic [2:0]  XO_WIDE  = 3'b101;

    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_SHORT = 2'd1,
        FORM_WIDE  = 2'd2
    } form_e;

    typedef struct packed {
        form_e              form;
        logic [IDX_W-1:0]   dst;
        logic [IDX_W-1:0]   src_a;
        logic [IDX_W-1:0]   src_b;
    } dec_t;

    // Instruction bit numbering: position k from the MSB is w[INSTR_W-1-k].
    function automatic dec_t decode_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        logic [SIDX_W-1:0] lo_d, lo_a, lo_b;
        lo_d = w[25:21];
        lo_a = w[20:16];
        lo_b = w[15:11];
        d.form  = FORM_NONE;
        d.dst   = {{(IDX_W-SIDX_W){1'b0}}, lo_d};
        d.src_a = {{(IDX_W-SIDX_W){1'b0}}, lo_a};
        d.src_b = {{(IDX_W-SIDX_W){1'b0}}, lo_b};
        if (w[31:26] == OP_SHORT && w[10:0] == XO_SHORT) begin
            d.form = FORM_SHORT;
        end else if (w[31:26] == OP_WIDE && w[8:6] == XO_WIDE) begin
            d.form  = FORM_WIDE;
            d.src_a = {w[10], w[5], lo_a};
            d.dst   = {w[3:2], lo_d};
            d.src_b = {w[1:0], lo_b};
        end
        return d;
    endfunction

endpackage

// File: rtl/vsa_decode.sv
module vsa_decode
    import vsa_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb begin
        dec = decode_word(instr);
    end
endmodule

// File: rtl/vsa_lane.sv
module vsa_lane #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opnd,
    input  logic [W-1:0] cnt_word,
    output logic [W-1:0] res
);
    localparam int unsigned CW = $clog2(W);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = cnt_word[CW-1:0];
        res = W'($signed(opnd) >>> cnt);
    end
endmodule

// File: rtl/vsa_unit.sv
module vsa_unit
    import vsa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  in_instr,
    output logic [IDX_W-1:0]    rd_addr_a,
    output logic [IDX_W-1:0]    rd_addr_b,
    input  logic [VEC_W-1:0]    rd_data_a,
    input  logic [VEC_W-1:0]    rd_data_b,
    output logic                wb_en,
    output logic [IDX_W-1:0]    wb_addr,
    output logic [VEC_W-1:0]    wb_data,
    output logic                bad_op
);
    dec_t             dec;
    logic [VEC_W-1:0] shifted;

    vsa_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    assign rd_addr_a = dec.src_a;
    assign rd_addr_b = dec.src_b;

    // Lane 0 is the most significant word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned HI = VEC_W - 1 - g * LANE_W;
        vsa_lane #(.W(LANE_W)) u_lane (
            .opnd     (rd_data_a[HI -: LANE_W]),
            .cnt_word (rd_data_b[HI -: LANE_W]),
            .res      (shifted[HI -: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en   <= 1'b0;
            bad_op  <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
        end else begin
            wb_en  <= in_valid && (dec.form != FORM_NONE);
            bad_op <= in_valid && (dec.form == FORM_NONE);
            if (in_valid) begin
                wb_addr <= dec.dst;
                wb_data <= shifted;
            end
        end
    end
endmodule

// File: rtl/vsa_unit_chk.sv
module vsa_unit_chk
    import vsa_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [INSTR_W-1:0]  in_instr,
    input logic [IDX_W-1:0]    rd_addr_a,
    input logic [IDX_W-1:0]    rd_addr_b,
    input logic [VEC_W-1:0]    rd_data_a,
    input logic [VEC_W-1:0]    rd_data_b,
    input logic                wb_en,
    input logic [IDX_W-1:0]    wb_addr,
    input logic [VEC_W-1:0]    wb_data,
    input logic                bad_op
);
    logic short_hit;
    assign short_hit = in_valid && in_instr[31:26] == 6'd4 && in_instr[10:0] == 11'h384;

    a_r1_short_write: assert property (@(posedge clk) disable iff (rst)
        short_hit |=> wb_en && wb_addr == {2'b00, $past(in_instr[25:21])});

    a_r9_short_read: assert property (@(posedge clk) disable iff (rst)
        short_hit |-> rd_addr_a == {2'b00, in_instr[20:16]} && rd_addr_b == {2'b00, in_instr[15:11]});

    a_r3_full_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rd_data_a[127] && rd_data_b[100:96] == 5'd31)
        |=> (!wb_en || wb_data[127:96] == 32'hFFFF_FFFF));

    a_r3_zero_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rd_data_b[4:0] == 5'd0)
        |=> (!wb_en || wb_data[31:0] == $past(rd_data_a[31:0])));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_en, bad_op}));

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !wb_en && !bad_op);
endmodule

bind vsa_unit vsa_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_instr  (in_instr),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .bad_op    (bad_op)
);

// File: tb/vsa_unit_test.sv
module vsa_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  in_instr;
    logic [6:0]   rd_addr_a, rd_addr_b, wb_addr;
    logic [127:0] rd_data_a, rd_data_b, wb_data;
    logic         wb_en, bad_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vsa_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .bad_op(bad_op)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Doc bit k is word bit 31-k.
    function automatic bit dbit(input logic [31:0] w, input int k);
        return w[31-k];
    endfunction

    function automatic logic [31:0] mk_short(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
        return 32'h1000_0384 | {6'd0, d, a, b, 11'd0};
    endfunction

    function automatic logic [31:0] mk_wide(input logic [6:0] d, input logic [6:0] a, input logic [6:0] b);
        logic [31:0] w;
        w = 32'h1800_0150 | {6'd0, d[4:0], a[4:0], b[4:0], 11'd0};
        w[31-21] = a[6];
        w[31-26] = a[5];
        w[31-28] = d[6];
        w[31-29] = d[5];
        w[31-30] = b[6];
        w[31-31] = b[5];
        return w;
    endfunction

    // Reference: returns kind 0 none, 1 compact, 2 wide, plus indices.
    function automatic int ref_decode(input logic [31:0] w, output logic [6:0] d,
                                      output logic [6:0] a, output logic [6:0] b);
        int op, xo;
        op = w[31:26];
        xo = w[10:0];
        d = {2'b00, w[25:21]};
        a = {2'b00, w[20:16]};
        b = {2'b00, w[15:11]};
        if (op == 4 && xo == 900) return 1;
        if (op == 6 && {dbit(w,23), dbit(w,24), dbit(w,25)} == 3'b101) begin
            a = {dbit(w,21), dbit(w,26), w[20:16]};
            d = {dbit(w,28), dbit(w,29), w[25:21]};
            b = {dbit(w,30), dbit(w,31), w[15:11]};
            return 2;
        end
        return 0;
    endfunction

    // Reference shift: one position at a time, copying the top bit in.
    function automatic logic [127:0] ref_shift(input logic [127:0] va, input logic [127:0] vb);
        logic [127:0] r;
        for (int lane = 0; lane < 4; lane++) begin
            logic [31:0] x;
            int n;
            x = va[127 - 32*lane -: 32];
            n = vb[127 - 32*lane -: 5] & 31;
            n = vb[96 - 32*lane +: 5];
            for (int s = 0; s < n; s++) x = {x[31], x[31:1]};
            r[127 - 32*lane -: 32] = x;
        end
        return r;
    endfunction

    task automatic issue(input bit v, input logic [31:0] w, input logic [127:0] va,
                         input logic [127:0] vb, input string tag);
        logic [6:0] ed, ea, eb;
        int kind;
        bit exp_wr, exp_bad;
        logic [127:0] exp_data;
        @(negedge clk);
        in_valid  = v;
        in_instr  = w;
        rd_data_a = va;
        rd_data_b = vb;
        kind = ref_decode(w, ed, ea, eb);
        exp_wr   = v && kind != 0;
        exp_bad  = v && kind == 0;
        exp_data = ref_shift(va, vb);
        #1;
        if (kind != 0) begin
            check(rd_addr_a == ea, {tag, " R9 rd_addr_a"}, 128'(rd_addr_a), 128'(ea));
            check(rd_addr_b == eb, {tag, " R9 rd_addr_b"}, 128'(rd_addr_b), 128'(eb));
        end
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        check(wb_en == exp_wr, {tag, " wb_en"}, 128'(wb_en), 128'(exp_wr));
        check(bad_op == exp_bad, {tag, " R6 bad_op"}, 128'(bad_op), 128'(exp_bad));
        if (exp_wr) begin
            check(wb_addr == ed, {tag, " wb_addr"}, 128'(wb_addr), 128'(ed));
            check(wb_data == exp_data, {tag, " wb_data"}, wb_data, exp_data);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] va_mix, vb_mix;
        logic [31:0]  w;
        rst = 1'b1;
        in_valid = 1'b0;
        in_instr = '0;
        rd_data_a = '0;
        rd_data_b = '0;
        repeat (3) @(posedge clk);
        #2;
        check(!wb_en && !bad_op, "R8 reset state", {wb_en, bad_op}, 128'd0);
        @(negedge clk);
        rst = 1'b0;

        // Mixed-sign lanes with counts 0, 1, 31, 16 (R3, R5).
        va_mix = {32'h8000_0001, 32'h7FFF_FFFF, 32'hF000_0000, 32'h1234_5678};
        vb_mix = {32'd0, 32'd1, 32'd31, 32'd16};
        issue(1'b1, mk_short(5'd3, 5'd7, 5'd30), va_mix, vb_mix, "R1 R3 R5 compact mixed");
        // Count 31 on a positive and negative lane (R3).
        issue(1'b1, mk_short(5'd31, 5'd0, 5'd1),
              {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001},
              {4{32'd31}}, "R3 count31");
        // Upper count bits set; effective counts 4, 0, 31, 8 (R4).
        issue(1'b1, mk_short(5'd9, 5'd10, 5'd11),
              {32'hC000_0000, 32'hDEAD_BEEF, 32'h4000_0000, 32'h8765_4321},
              {32'hFFFF_FFE4, 32'hFFFF_FFE0, 32'h8000_001F, 32'h7FFF_FF08}, "R4 upper ignored");
        // Per-lane counts swapped around, to separate lanes (R5).
        issue(1'b1, mk_short(5'd1, 5'd2, 5'd3),
              {4{32'h8000_0000}}, {32'd3, 32'd7, 32'd11, 32'd29}, "R5 lane order");
        // Wide form with upper index bits (R2).
        issue(1'b1, mk_wide(7'h65, 7'h5A, 7'h33), va_mix, vb_mix, "R2 wide indices");
        issue(1'b1, mk_wide(7'h7F, 7'h7F, 7'h7F), va_mix, {32'd2, 32'd30, 32'd5, 32'd0}, "R2 wide all ones");
        // Reserved bits 22 and 27 flipped (R7).
        w = mk_wide(7'h41, 7'h22, 7'h14);
        w[31-22] = 1'b1;
        w[31-27] = 1'b0;
        issue(1'b1, w, va_mix, vb_mix, "R7 reserved ignored");
        // Near-miss wide: bits 23-25 = 3'b100 (R6).
        w = mk_wide(7'h10, 7'h20, 7'h30);
        w[31-25] = 1'b0;
        issue(1'b1, w, va_mix, vb_mix, "R6 near miss wide");
        // Near-miss compact: extended opcode 901 (R6).
        issue(1'b1, mk_short(5'd1, 5'd2, 5'd3) + 32'd1, va_mix, vb_mix, "R6 near miss compact");
        // Valid encoding while in_valid is low (R8).
        issue(1'b0, mk_short(5'd4, 5'd5, 5'd6), va_mix, vb_mix, "R8 idle");
        issue(1'b0, 32'hFFFF_FFFF, va_mix, vb_mix, "R8 idle junk");

        for (int i = 0; i < 40; i++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            case (i % 3)
                0: w = mk_short(5'($urandom), 5'($urandom), 5'($urandom));
                1: w = mk_wide(7'($urandom), 7'($urandom), 7'($urandom));
                default: w = $urandom;
            endcase
            issue(1'b1, w, ra, rb, "R1 R2 R3 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule